// File: doc/BRIEF.md
# Mesh Route Planner

This block plans how one byte travels across a rectangular grid of small processing cores, from a source core and register to a destination core and register. It does not move the byte. It produces the list of hops that a later stage turns into transfer instructions. It walks the grid one hop at a time. At every step it looks at the neighbours that bring the byte one step nearer the destination: at most one candidate on the row axis and one on the column axis. It goes to the candidate whose core reports the lower utilization.

A table inside the block holds two values for every core: a utilization percentage and a mask of free temporary registers. A write port loads the table while the planner is idle. Each intermediate hop takes the lowest-numbered free register in the core it lands on and marks that register as used. Later routes therefore avoid it. The last hop writes into the destination register that the request names.

A request is accepted through a valid/ready pair. Hop records leave through a second valid/ready pair, at most one record per cycle. A done pulse ends every route. The error flag comes with that pulse when a core on the path has no free register.

Top module: `route_planner`

## Requirements
- R1: Every hop record moves the byte by exactly one core, along one axis only, and each step brings it nearer the destination.
- R2: When the row and the column both differ from the destination, the hop goes to the candidate core with the lower utilization value.
- R3: When both candidates report equal utilization, the hop changes the row index (row-axis move) rather than the column index.
- R4: When only one coordinate differs from the destination, the single candidate on that axis is taken without comparing utilization.
- R5: The first hop's from-register is the requested source register. Each later hop's from-core and from-register equal the previous hop's to-core and to-register. The last hop, flagged by hop_last, targets the destination core and the requested destination register.
- R6: An intermediate hop targets the lowest-index register whose bit is set in the target core's free mask (bit k set means register k is free). That bit is then cleared, so a later route through the same core receives the next register.
- R7: A record presented with hop_valid high and hop_ready low stays unchanged until it is accepted. While hop_ready is high, a new record can be accepted in every cycle.
- R8: If the core for the next intermediate hop has no free register, no further record is issued, and the route ends with route_done and route_err both high.
- R9: route_done is a one-cycle pulse raised after the last record of the route has been accepted. When the source equals the destination, the route issues no records and ends with route_done high and route_err low.
- R10: req_ready is high only while the planner is idle. A request is taken in a cycle where req_valid and req_ready are both high, and req_ready is low in the cycle after it is taken.
- R11: After reset, no record is valid, route_done is low, and req_ready is high. Every core's utilization is 0 and its free mask is all ones.
- R12: A write with cfg_we high while idle loads the utilization value and the free mask of the core at (cfg_row, cfg_col). Later routes use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe (honoured when idle) |
| cfg_row | input | ROW_W | Row of the core being written |
| cfg_col | input | COL_W | Column of the core being written |
| cfg_util | input | UTIL_W | Utilization percentage to store |
| cfg_free | input | NREG | Free-register mask to store |
| req_valid | input | 1 | Route request valid |
| req_ready | output | 1 | Planner idle, request can be taken |
| req_src_row | input | ROW_W | Source core row |
| req_src_col | input | COL_W | Source core column |
| req_src_reg | input | REG_W | Source register |
| req_dst_row | input | ROW_W | Destination core row |
| req_dst_col | input | COL_W | Destination core column |
| req_dst_reg | input | REG_W | Destination register |
| hop_valid | output | 1 | Hop record valid |
| hop_ready | input | 1 | Consumer takes the hop record |
| hop_from_row | output | ROW_W | Hop start row |
| hop_from_col | output | COL_W | Hop start column |
| hop_from_reg | output | REG_W | Register read at the hop start |
| hop_to_row | output | ROW_W | Hop end row |
| hop_to_col | output | COL_W | Hop end column |
| hop_to_reg | output | REG_W | Register written at the hop end |
| hop_last | output | 1 | Record is the final hop of the route |
| route_done | output | 1 | One-cycle end-of-route pulse |
| route_err | output | 1 | Route stopped for lack of a free register (valid with route_done) |

## Verification
With hop_ready held high, the first hop record is valid one cycle after the request is accepted, and one record follows in each later cycle. route_done comes one or two cycles after the last handshake. When an error stops the route, route_done comes one cycle after the stall is detected. Because of these one-or-two-cycle windows, the bench does not sample at fixed offsets. It applies hop_ready at the falling edge and then samples a moment later. A handshake is counted only when valid and ready are both high before the next rising edge. The done pulse is awaited with a per-route cycle limit. A reference walk of the grid, kept in the bench, gives the exact record sequence, the hop count and the error outcome. Under alternating backpressure, every stalled record is compared against its value in the previous cycle.

// File: rtl/route_pkg.sv
package route_pkg;

  typedef enum logic [1:0] {
    PL_IDLE = 2'd0,
    PL_RUN  = 2'd1,
    PL_FIN  = 2'd2
  } plan_state_e;

endpackage

// File: rtl/route_util_table.sv
module route_util_table #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int UTIL_W = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [UTIL_W-1:0]    wr_util,
  input  logic [IDX_W-1:0]     rd_a_idx,
  output logic [UTIL_W-1:0]    rd_a_util,
  input  logic [IDX_W-1:0]     rd_b_idx,
  output logic [UTIL_W-1:0]    rd_b_util
);
  localparam int CORES = ROWS * COLS;
  localparam int IDX_W = (CORES > 1) ? $clog2(CORES) : 1;

  logic [UTIL_W-1:0] util_q [CORES];

  // one entry per core; reset clears the load figure of every core
  for (genvar g = 0; g < CORES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        util_q[g] <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        util_q[g] <= wr_util;
      end
    end
  end

  // two asynchronous read ports: both candidates are compared in one cycle
  assign rd_a_util = util_q[rd_a_idx];
  assign rd_b_util = util_q[rd_b_idx];

endmodule

// File: rtl/route_free_table.sv
module route_free_table #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [NREG-1:0]   wr_mask,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic [REG_W-1:0]  clr_reg,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [NREG-1:0]   rd_mask
);
  localparam int CORES = ROWS * COLS;
  localparam int IDX_W = (CORES > 1) ? $clog2(CORES) : 1;
  localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [NREG-1:0] mask_q [CORES];

  // allocation has priority over a table load
  for (genvar g = 0; g < CORES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[g] <= '1;
      end else if (clr_en && (clr_idx == IDX_W'(g))) begin
        mask_q[g][clr_reg] <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        mask_q[g] <= wr_mask;
      end
    end
  end

  assign rd_mask = mask_q[rd_idx];

  AST_CLR_ONLY_FREE: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> mask_q[clr_idx][clr_reg]) else $error("allocated register was not free"); // R6

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> !mask_q[$past(clr_idx)][$past(clr_reg)]) else $error("allocated register still free"); // R6

endmodule

// File: rtl/route_free_pick.sv
module route_free_pick #(
  parameter int NREG = 8
) (
  input  logic [NREG-1:0]  mask,
  output logic             any_free,
  output logic [REG_W-1:0] pick_idx
);
  localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1;

  // lowest set bit wins: scan downward so the last hit is the smallest index
  always_comb begin
    any_free = |mask;
    pick_idx = '0;
    for (int k = NREG - 1; k >= 0; k--) begin
      if (mask[k]) pick_idx = REG_W'(k);
    end
  end

endmodule

// File: rtl/route_hop_select.sv
module route_hop_select #(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int UTIL_W = 7
) (
  input  logic [ROW_W-1:0]  cur_row,
  input  logic [COL_W-1:0]  cur_col,
  input  logic [ROW_W-1:0]  dst_row,
  input  logic [COL_W-1:0]  dst_col,
  output logic [IDX_W-1:0]  cand_r_idx,
  output logic [IDX_W-1:0]  cand_c_idx,
  input  logic [UTIL_W-1:0] util_r,
  input  logic [UTIL_W-1:0] util_c,
  output logic              take_row,
  output logic [ROW_W-1:0]  nxt_row,
  output logic [COL_W-1:0]  nxt_col,
  output logic [IDX_W-1:0]  nxt_idx
);
  localparam int CORES = ROWS * COLS;
  localparam int IDX_W = (CORES > 1) ? $clog2(CORES) : 1;
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;

  logic [ROW_W-1:0] cand_row;
  logic [COL_W-1:0] cand_col;
  logic             row_moves;
  logic             col_moves;

  // candidate coordinates depend only on position and target
  always_comb begin
    row_moves = (cur_row != dst_row);
    col_moves = (cur_col != dst_col);
    if (dst_row > cur_row)      cand_row = cur_row + ROW_W'(1);
    else if (dst_row < cur_row) cand_row = cur_row - ROW_W'(1);
    else                        cand_row = cur_row;
    if (dst_col > cur_col)      cand_col = cur_col + COL_W'(1);
    else if (dst_col < cur_col) cand_col = cur_col - COL_W'(1);
    else                        cand_col = cur_col;
    cand_r_idx = IDX_W'(cand_row) * IDX_W'(COLS) + IDX_W'(cur_col);
    cand_c_idx = IDX_W'(cur_row)  * IDX_W'(COLS) + IDX_W'(cand_col);
  end

  // choice: lower load wins, equal load favours the row-axis move
  always_comb begin
    if (row_moves && col_moves) take_row = (util_r <= util_c);
    else                        take_row = row_moves;
    nxt_row = take_row ? cand_row   : cur_row;
    nxt_col = take_row ? cur_col    : cand_col;
    nxt_idx = take_row ? cand_r_idx : cand_c_idx;
  end

endmodule

// File: rtl/route_planner.sv
module route_planner
  import route_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int NREG   = 8,
  parameter int UTIL_W = 7,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int REG_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ROW_W-1:0]  cfg_row,
  input  logic [COL_W-1:0]  cfg_col,
  input  logic [UTIL_W-1:0] cfg_util,
  input  logic [NREG-1:0]   cfg_free,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ROW_W-1:0]  req_src_row,
  input  logic [COL_W-1:0]  req_src_col,
  input  logic [REG_W-1:0]  req_src_reg,
  input  logic [ROW_W-1:0]  req_dst_row,
  input  logic [COL_W-1:0]  req_dst_col,
  input  logic [REG_W-1:0]  req_dst_reg,
  output logic              hop_valid,
  input  logic              hop_ready,
  output logic [ROW_W-1:0]  hop_from_row,
  output logic [COL_W-1:0]  hop_from_col,
  output logic [REG_W-1:0]  hop_from_reg,
  output logic [ROW_W-1:0]  hop_to_row,
  output logic [COL_W-1:0]  hop_to_col,
  output logic [REG_W-1:0]  hop_to_reg,
  output logic              hop_last,
  output logic              route_done,
  output logic              route_err
);
  localparam int CORES = ROWS * COLS;
  localparam int IDX_W = (CORES > 1) ? $clog2(CORES) : 1;

  plan_state_e       state_q;
  logic [ROW_W-1:0]  cur_row_q, dst_row_q;
  logic [COL_W-1:0]  cur_col_q, dst_col_q;
  logic [REG_W-1:0]  cur_reg_q, dst_reg_q;
  logic              err_q;

  logic              hop_valid_q, hop_last_q;
  logic [ROW_W-1:0]  from_row_q, to_row_q;
  logic [COL_W-1:0]  from_col_q, to_col_q;
  logic [REG_W-1:0]  from_reg_q, to_reg_q;
  logic              done_q, err_out_q;

  logic [IDX_W-1:0]  cand_r_idx, cand_c_idx, nxt_idx, cfg_idx;
  logic [UTIL_W-1:0] util_r, util_c;
  logic              take_row;
  logic [ROW_W-1:0]  nxt_row;
  logic [COL_W-1:0]  nxt_col;
  logic [NREG-1:0]   nxt_mask;
  logic              pick_any;
  logic [REG_W-1:0]  pick_idx;

  logic              cfg_en, at_dst, nxt_final, slot_free, can_step, step_go, clr_en;
  logic [REG_W-1:0]  step_reg;

  assign cfg_en    = cfg_we && (state_q == PL_IDLE);
  assign cfg_idx   = IDX_W'(cfg_row) * IDX_W'(COLS) + IDX_W'(cfg_col);
  assign at_dst    = (cur_row_q == dst_row_q) && (cur_col_q == dst_col_q);
  assign nxt_final = (nxt_row == dst_row_q) && (nxt_col == dst_col_q);
  assign slot_free = !hop_valid_q || hop_ready;
  assign can_step  = nxt_final || pick_any;
  assign step_go   = (state_q == PL_RUN) && !at_dst && slot_free && can_step;
  assign clr_en    = step_go && !nxt_final;
  assign step_reg  = nxt_final ? dst_reg_q : pick_idx;

  route_util_table #(.ROWS(ROWS), .COLS(COLS), .UTIL_W(UTIL_W)) u_util (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_en),
    .wr_idx    (cfg_idx),
    .wr_util   (cfg_util),
    .rd_a_idx  (cand_r_idx),
    .rd_a_util (util_r),
    .rd_b_idx  (cand_c_idx),
    .rd_b_util (util_c)
  );

  route_hop_select #(.ROWS(ROWS), .COLS(COLS), .UTIL_W(UTIL_W)) u_sel (
    .cur_row    (cur_row_q),
    .cur_col    (cur_col_q),
    .dst_row    (dst_row_q),
    .dst_col    (dst_col_q),
    .cand_r_idx (cand_r_idx),
    .cand_c_idx (cand_c_idx),
    .util_r     (util_r),
    .util_c     (util_c),
    .take_row   (take_row),
    .nxt_row    (nxt_row),
    .nxt_col    (nxt_col),
    .nxt_idx    (nxt_idx)
  );

  route_free_table #(.ROWS(ROWS), .COLS(COLS), .NREG(NREG)) u_free (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_en),
    .wr_idx  (cfg_idx),
    .wr_mask (cfg_free),
    .clr_en  (clr_en),
    .clr_idx (nxt_idx),
    .clr_reg (pick_idx),
    .rd_idx  (nxt_idx),
    .rd_mask (nxt_mask)
  );

  route_free_pick #(.NREG(NREG)) u_pick (
    .mask     (nxt_mask),
    .any_free (pick_any),
    .pick_idx (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= PL_IDLE;
      cur_row_q   <= '0;
      cur_col_q   <= '0;
      cur_reg_q   <= '0;
      dst_row_q   <= '0;
      dst_col_q   <= '0;
      dst_reg_q   <= '0;
      err_q       <= 1'b0;
      hop_valid_q <= 1'b0;
      hop_last_q  <= 1'b0;
      from_row_q  <= '0;
      from_col_q  <= '0;
      from_reg_q  <= '0;
      to_row_q    <= '0;
      to_col_q    <= '0;
      to_reg_q    <= '0;
      done_q      <= 1'b0;
      err_out_q   <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      err_out_q <= 1'b0;
      if (hop_valid_q && hop_ready) hop_valid_q <= 1'b0;
      unique case (state_q)
        PL_IDLE: begin
          if (req_valid) begin
            cur_row_q <= req_src_row;
            cur_col_q <= req_src_col;
            cur_reg_q <= req_src_reg;
            dst_row_q <= req_dst_row;
            dst_col_q <= req_dst_col;
            dst_reg_q <= req_dst_reg;
            err_q     <= 1'b0;
            state_q   <= PL_RUN;
          end
        end
        PL_RUN: begin
          if (at_dst) begin
            state_q <= PL_FIN;
          end else if (slot_free) begin
            if (can_step) begin
              hop_valid_q <= 1'b1;
              hop_last_q  <= nxt_final;
              from_row_q  <= cur_row_q;
              from_col_q  <= cur_col_q;
              from_reg_q  <= cur_reg_q;
              to_row_q    <= nxt_row;
              to_col_q    <= nxt_col;
              to_reg_q    <= step_reg;
              cur_row_q   <= nxt_row;
              cur_col_q   <= nxt_col;
              cur_reg_q   <= step_reg;
            end else begin
              err_q   <= 1'b1;
              state_q <= PL_FIN;
            end
          end
        end
        PL_FIN: begin
          if (slot_free) begin
            done_q    <= 1'b1;
            err_out_q <= err_q;
            state_q   <= PL_IDLE;
          end
        end
        default: state_q <= PL_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == PL_IDLE);
  assign hop_valid    = hop_valid_q;
  assign hop_last     = hop_last_q;
  assign hop_from_row = from_row_q;
  assign hop_from_col = from_col_q;
  assign hop_from_reg = from_reg_q;
  assign hop_to_row   = to_row_q;
  assign hop_to_col   = to_col_q;
  assign hop_to_reg   = to_reg_q;
  assign route_done   = done_q;
  assign route_err    = err_out_q;

  AST_HOP_ADJACENT: assert property (@(posedge clk) disable iff (rst)
    hop_valid_q |->
      ((from_row_q == to_row_q) &&
       ((int'(to_col_q) - int'(from_col_q) == 1) || (int'(to_col_q) - int'(from_col_q) == -1))) ||
      ((from_col_q == to_col_q) &&
       ((int'(to_row_q) - int'(from_row_q) == 1) || (int'(to_row_q) - int'(from_row_q) == -1))))
    else $error("hop is not a single neighbour step"); // R1

  AST_HOLD_RECORD: assert property (@(posedge clk) disable iff (rst)
    (hop_valid_q && !hop_ready) |=>
      (hop_valid_q && $stable(from_row_q) && $stable(from_col_q) && $stable(from_reg_q) &&
       $stable(to_row_q) && $stable(to_col_q) && $stable(to_reg_q) && $stable(hop_last_q)))
    else $error("stalled record changed"); // R7

  AST_LAST_AT_DEST: assert property (@(posedge clk) disable iff (rst)
    (hop_valid_q && hop_last_q) |->
      (to_row_q == dst_row_q && to_col_q == dst_col_q && to_reg_q == dst_reg_q))
    else $error("final hop misses destination"); // R5

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    route_err |-> route_done) else $error("error flag without done"); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    route_done |=> !route_done) else $error("done held longer than one cycle"); // R9

  AST_NO_HOP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (req_ready && !$past(hop_valid_q)) |-> !hop_valid_q) else $error("record while idle"); // R10

endmodule

// File: tb/route_planner_tb.sv
`timescale 1ns/1ps
module route_planner_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_row = '0, cfg_col = '0;
  logic [6:0] cfg_util = '0;
  logic [7:0] cfg_free = '0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_src_row = '0, req_src_col = '0, req_dst_row = '0, req_dst_col = '0;
  logic [2:0] req_src_reg = '0, req_dst_reg = '0;
  logic       hop_valid;
  logic       hop_ready = 1'b1;
  logic [1:0] hop_from_row, hop_from_col, hop_to_row, hop_to_col;
  logic [2:0] hop_from_reg, hop_to_reg;
  logic       hop_last, route_done, route_err;

  int tests = 0;
  int fails = 0;

  int m_util [4][4];
  int m_free [4][4];

  always #4 clk = ~clk;

  route_planner dut_i (
    .clk (clk), .rst (rst),
    .cfg_we (cfg_we), .cfg_row (cfg_row), .cfg_col (cfg_col),
    .cfg_util (cfg_util), .cfg_free (cfg_free),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_src_row (req_src_row), .req_src_col (req_src_col), .req_src_reg (req_src_reg),
    .req_dst_row (req_dst_row), .req_dst_col (req_dst_col), .req_dst_reg (req_dst_reg),
    .hop_valid (hop_valid), .hop_ready (hop_ready),
    .hop_from_row (hop_from_row), .hop_from_col (hop_from_col), .hop_from_reg (hop_from_reg),
    .hop_to_row (hop_to_row), .hop_to_col (hop_to_col), .hop_to_reg (hop_to_reg),
    .hop_last (hop_last), .route_done (route_done), .route_err (route_err)
  );

  // routes walked by the main loop: src row, col, reg, dst row, col, reg, hop count
  localparam int NCASE = 5;
  localparam int CASE_TAB [NCASE][7] = '{
    '{0, 0, 1, 3, 2, 3, 5},
    '{0, 0, 1, 3, 2, 3, 5},
    '{3, 3, 2, 0, 0, 5, 6},
    '{2, 1, 0, 2, 3, 4, 2},
    '{1, 2, 6, 0, 1, 7, 2}
  };

  localparam int GRID [4][4] = '{
    '{80, 66, 90, 100},
    '{20, 70, 40, 90},
    '{100, 80, 56, 65},
    '{90, 10, 34, 99}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int pack_rec(int fr, int fc, int fg, int tr, int tc, int tg, int last);
    return (fr << 24) | (fc << 20) | (fg << 16) | (tr << 12) | (tc << 8) | (tg << 4) | last;
  endfunction

  function automatic int step1(int cur, int dst);
    if (dst > cur) return cur + 1;
    if (dst < cur) return cur - 1;
    return cur;
  endfunction

  task automatic cfg_write(input int r, input int c, input int u, input int m);
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = 2'(r); cfg_col = 2'(c); cfg_util = 7'(u); cfg_free = 8'(m);
    @(negedge clk);
    cfg_we = 1'b0;
    m_util[r][c] = u;
    m_free[r][c] = m;
  endtask

  task automatic run_route(input int sr, input int sc, input int sg, input int dr, input int dc,
                           input int dg, input bit bp, input int exp_hops, input string tag);
    int exp_rec [16];
    int n = 0;
    bit err = 0;
    int cr = sr, cc = sc, cg = sg;
    int got = 0, cyc = 0, prev_rec = 0, cur_rec;
    bit prev_stall = 0, done_seen = 0;
    // reference walk of the requirements: greedy lower load, tie to the row axis
    while ((cr != dr || cc != dc) && n < 16) begin
      int rr = step1(cr, dr);
      int rc = step1(cc, dc);
      bit tr_;
      int nr, nc, tg;
      bit fin;
      if (cr != dr && cc != dc) tr_ = (m_util[rr][cc] <= m_util[cr][rc]);
      else                      tr_ = (cr != dr);
      nr = tr_ ? rr : cr;
      nc = tr_ ? cc : rc;
      fin = (nr == dr && nc == dc);
      if (fin) tg = dg;
      else begin
        tg = -1;
        for (int k = 7; k >= 0; k--) if (m_free[nr][nc][k]) tg = k;
        if (tg < 0) begin err = 1; break; end
        m_free[nr][nc] = m_free[nr][nc] & ~(1 << tg);
      end
      exp_rec[n] = pack_rec(cr, cc, cg, nr, nc, tg, int'(fin));
      n++;
      cr = nr; cc = nc; cg = tg;
    end
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready before request", int'(req_ready), 1);
    req_src_row = 2'(sr); req_src_col = 2'(sc); req_src_reg = 3'(sg);
    req_dst_row = 2'(dr); req_dst_col = 2'(dc); req_dst_reg = 3'(dg);
    req_valid = 1'b1;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", "ready after accept", int'(req_ready), 0);
    while (!done_seen && cyc < 200) begin
      @(negedge clk);
      hop_ready = bp ? cyc[0] : 1'b1;
      #1;
      cur_rec = pack_rec(int'(hop_from_row), int'(hop_from_col), int'(hop_from_reg),
                         int'(hop_to_row), int'(hop_to_col), int'(hop_to_reg), int'(hop_last));
      if (prev_stall) chk(hop_valid && cur_rec == prev_rec, "R7", "stalled record held", cur_rec, prev_rec);
      prev_stall = hop_valid && !hop_ready;
      prev_rec = cur_rec;
      if (hop_valid && hop_ready) begin
        if (got < n) chk(cur_rec == exp_rec[got], tag, "hop record", cur_rec, exp_rec[got]);
        else         chk(1'b0, tag, "extra hop record", cur_rec, 0);
        got++;
      end
      if (route_done) begin
        done_seen = 1;
        chk(route_err == err, "R8", "error flag at done", int'(route_err), int'(err));
      end
      cyc++;
    end
    chk(done_seen, "R9", "done pulse seen", int'(done_seen), 1);
    chk(got == n, tag, "hop count vs walk", got, n);
    if (exp_hops >= 0) chk(got == exp_hops, tag, "hop count vs table", got, exp_hops);
    @(negedge clk);
    chk(route_done == 1'b0, "R9", "done is one cycle", int'(route_done), 0);
    hop_ready = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        m_util[r][c] = 0;
        m_free[r][c] = 8'hFF;
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R11: idle outputs after reset
    chk(hop_valid == 1'b0, "R11", "hop_valid after reset", int'(hop_valid), 0);
    chk(route_done == 1'b0, "R11", "route_done after reset", int'(route_done), 0);
    chk(req_ready == 1'b1, "R11", "req_ready after reset", int'(req_ready), 1);

    // R11 and R3: all loads zero, so the tie takes the row step; register 0 is free
    run_route(0, 0, 0, 1, 1, 2, 1'b0, 2, "R3/R11");

    // R9: source equals destination
    run_route(2, 2, 3, 2, 2, 3, 1'b0, 0, "R9");

    // R12: load the load grid
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        cfg_write(r, c, GRID[r][c], 8'hFF);

    // R2, R4, R5, R6, R1 through the route table
    for (int k = 0; k < NCASE; k++)
      run_route(CASE_TAB[k][0], CASE_TAB[k][1], CASE_TAB[k][2],
                CASE_TAB[k][3], CASE_TAB[k][4], CASE_TAB[k][5], 1'b0, CASE_TAB[k][6],
                "R1/R2/R4/R5/R6");

    // R7: alternating backpressure on a long route
    run_route(3, 0, 1, 0, 3, 2, 1'b1, 6, "R7/R5");

    // R8: first intermediate core full, no hop at all
    cfg_write(1, 1, GRID[1][1], 0);
    run_route(0, 1, 2, 2, 1, 4, 1'b0, 0, "R8");
    cfg_write(1, 1, GRID[1][1], 8'hFF);

    // R8: one hop, then a full core stops the route
    cfg_write(0, 2, GRID[0][2], 0);
    run_route(0, 0, 0, 0, 3, 1, 1'b0, 1, "R8");

    // R12 and R6: reload one mask with only register 5 free
    cfg_write(0, 2, 5, 8'h20);
    run_route(0, 1, 3, 0, 3, 6, 1'b0, 2, "R12/R6");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule